// File: doc/BRIEF.md
# Systolic Serial Bit-Pattern Matcher

This block scans a serial stream of bits and reports every position where a fixed pattern of `PAT_LEN` bits appears, overlapping occurrences included. The pattern is captured from the `pattern_in` port while reset is held. After reset the host offers one stream bit at a time with a strobe. For every accepted bit that completes a full window, the block returns a one-cycle result pulse that says whether the newest `PAT_LEN` bits equal the pattern.

The core is a linear chain of identical cells, one per pattern bit. Each cell holds one pattern bit. Stream bits move through the chain in one direction and result tokens move in the other. A token starts at the far end with the value 1 and is ANDed with each cell's bit comparison as it passes. Every accepted bit is held for two internal steps, so a token meets each stream bit in exactly one cell. The chain only advances while a bit is being consumed, so the host may leave idle cycles of any length between bits.

Top module: `pm_systolic_matcher`

## Requirements
- R1: While reset is high, and after it until `PAT_LEN` bits have been accepted, `match_valid` and `match_hit` stay low.
- R2: The pattern is taken from `pattern_in` only while `rst` is high. Changes of `pattern_in` outside reset have no effect on any result.
- R3: A bit is accepted when `in_valid` is high and the previous cycle did not accept a bit. A strobe in the cycle right after an accepted bit is ignored: it is neither consumed nor counted.
- R4: When the k-th accepted bit since reset has k >= `PAT_LEN`, `match_valid` is high for exactly one cycle, the cycle right after that acceptance. There is no other `match_valid` pulse.
- R5: During that pulse, `match_hit` is 1 exactly when `pattern_in[j]` equals accepted bit number k-`PAT_LEN`+1+j for every j. Bit 0 of the pattern pairs with the oldest bit of the window.
- R6: `match_hit` is low in every cycle in which `match_valid` is low.
- R7: Idle cycles of any length between accepted bits do not change any result.
- R8: Overlapping occurrences are each reported. With pattern 101 and stream 1,0,1,0,1, the pulses report 1,0,1.
- R9: A reset during a stream discards the partial window. `PAT_LEN` new bits are needed before the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; the pattern is captured while it is high |
| pattern_in | input | PAT_LEN | Pattern to find; bit 0 pairs with the oldest bit of the window |
| in_valid | input | 1 | Strobe offering `in_bit` |
| in_bit | input | 1 | Serial stream bit |
| match_valid | output | 1 | One-cycle pulse per completed window |
| match_hit | output | 1 | 1 when the window equals the pattern; valid with `match_valid` |

## Verification
Each result is registered at the clock edge that accepts the bit completing its window, so the pulse is due one cycle after acceptance. It must be gone again one cycle later, when the second internal step of the same bit runs. The bench drives and samples on the falling edge. After each accepted bit it reads the pulse and the hit at the next falling edge, then confirms the pulse is low at the falling edge after that and during any idle cycles. Expected hits come from a plain sliding-window comparison over the bits the bench knows were accepted. An ignored strobe is therefore never entered into the model, and later results show whether the block consumed it.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // stream slot travelling forward through the chain
    typedef struct packed {
        logic val;   // stream bit value
        logic ok;    // slot carries a real accepted bit
    } xslot_t;

    // result token travelling backward through the chain
    typedef struct packed {
        logic hit;   // running AND of comparisons
        logic live;  // token present and all seen bits were real
    } tok_t;

    // a token must be injected on the first step of a bit when the chain
    // length is odd, on the second step otherwise; this makes each token
    // leave the chain on the first step of the bit closing its window
    function automatic logic inject_first(input int unsigned len);
        return ((len - 1) % 2) == 0;
    endfunction

    function automatic logic bit_agrees(input logic x, input logic w);
        return x ~^ w;
    endfunction

endpackage

// File: rtl/pm_feed.sv
module pm_feed
    import pm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_bit,
    output logic   step,
    output logic   first_step,
    output logic   hold_q,
    output xslot_t feed
);
    logic accept;
    logic held_bit_q;

    // a strobe during the hold cycle is dropped
    assign accept     = in_valid & ~hold_q;
    assign first_step = accept;
    assign step       = accept | hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            held_bit_q <= 1'b0;
        end else begin
            hold_q <= accept;
            if (accept) begin
                held_bit_q <= in_bit;
            end
        end
    end

    always_comb begin
        feed.val = accept ? in_bit : held_bit_q;
        feed.ok  = step;
    end

endmodule

// File: rtl/pm_pattern.sv
module pm_pattern #(
    parameter int unsigned PAT_LEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PAT_LEN-1:0] pattern_in,
    output logic [PAT_LEN-1:0] weight_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            weight_q <= pattern_in;
        end
    end
endmodule

// File: rtl/pm_cell.sv
module pm_cell
    import pm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   weight,
    input  xslot_t x_in,
    input  tok_t   y_in,
    output xslot_t x_q,
    output tok_t   y_q
);
    logic agree;

    assign agree = bit_agrees(x_in.val, weight);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (step) begin
            x_q      <= x_in;
            y_q.live <= y_in.live & x_in.ok;
            y_q.hit  <= y_in.hit & x_in.ok & agree;
        end
    end
endmodule

// File: rtl/pm_systolic_matcher.sv
module pm_systolic_matcher
    import pm_pkg::*;
#(
    parameter int unsigned PAT_LEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PAT_LEN-1:0] pattern_in,
    input  logic               in_valid,
    input  logic               in_bit,
    output logic               match_valid,
    output logic               match_hit
);
    localparam int unsigned LAST     = PAT_LEN - 1;
    localparam logic        INJ_HEAD = inject_first(PAT_LEN);

    logic               step;
    logic               first_step;
    logic               hold_q;
    xslot_t             feed;
    logic [PAT_LEN-1:0] weight_q;
    tok_t               inject;

    xslot_t cell_x_in [PAT_LEN];
    tok_t   cell_y_in [PAT_LEN];
    xslot_t cell_x_q  [PAT_LEN];
    tok_t   cell_y_q  [PAT_LEN];

    pm_feed u_feed (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .step       (step),
        .first_step (first_step),
        .hold_q     (hold_q),
        .feed       (feed)
    );

    pm_pattern #(.PAT_LEN(PAT_LEN)) u_pattern (
        .clk        (clk),
        .rst        (rst),
        .pattern_in (pattern_in),
        .weight_q   (weight_q)
    );

    // fresh token (value 1) enters the far cell on one phase of each bit
    always_comb begin
        inject.live = INJ_HEAD ? first_step : hold_q;
        inject.hit  = inject.live;
    end

    for (genvar k = 0; k < PAT_LEN; k++) begin : g_cell
        if (k == 0) begin : g_head
            assign cell_x_in[k] = feed;
        end else begin : g_body
            assign cell_x_in[k] = cell_x_q[k-1];
        end

        if (k == LAST) begin : g_tail
            assign cell_y_in[k] = inject;
        end else begin : g_mid
            assign cell_y_in[k] = cell_y_q[k+1];
        end

        // cell k sees the bit k places older than the newest one
        pm_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .step   (step),
            .weight (weight_q[LAST-k]),
            .x_in   (cell_x_in[k]),
            .y_in   (cell_y_in[k]),
            .x_q    (cell_x_q[k]),
            .y_q    (cell_y_q[k])
        );
    end

    assign match_valid = cell_y_q[0].live;
    assign match_hit   = cell_y_q[0].live & cell_y_q[0].hit;

endmodule

// File: rtl/pm_matcher_chk.sv
module pm_matcher_chk #(
    parameter int unsigned N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         hold_q,
    input logic [N-1:0] weight_q,
    input logic         match_valid,
    input logic         match_hit
);
    localparam int unsigned CW = $clog2(N + 1) + 1;

    logic [CW-1:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt <= '0;
        end else if (in_valid && !hold_q && acc_cnt < CW'(N)) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    // R6
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        match_hit |-> match_valid);

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);

    // R4
    pulse_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(in_valid));

    // R1
    fill_before_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> (acc_cnt >= CW'(N)));

    // R3
    strobe_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |=> !hold_q);

    // R2
    weights_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(weight_q));

endmodule

bind pm_systolic_matcher pm_matcher_chk #(.N(PAT_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .hold_q      (hold_q),
    .weight_q    (weight_q),
    .match_valid (match_valid),
    .match_hit   (match_hit)
);

// File: tb/pm_systolic_matcher_bench.sv
module pm_systolic_matcher_bench;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pattern_in = '0;
    logic         in_valid = 1'b0;
    logic         in_bit = 1'b0;
    logic         match_valid;
    logic         match_hit;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] pat_m;
    logic hist [0:2047];
    int n = 0;

    always #2 clk = ~clk;

    pm_systolic_matcher #(.PAT_LEN(N)) u_pm_systolic_matcher (
        .clk(clk), .rst(rst), .pattern_in(pattern_in),
        .in_valid(in_valid), .in_bit(in_bit),
        .match_valid(match_valid), .match_hit(match_hit)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (bits=%0d)", tag, act, exp, n);
        end
    endtask

    function automatic logic exp_hit();
        for (int j = 0; j < N; j++)
            if (pat_m[j] != hist[n-N+j]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_reset(input logic [N-1:0] p);
        @(negedge clk);
        rst = 1'b1; pattern_in = p; in_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 valid in reset", match_valid, 1'b0);
        end
        rst = 1'b0; pat_m = p; n = 0;
        @(negedge clk);
        chk("R1 valid after reset", match_valid, 1'b0);
        chk("R1 hit after reset", match_hit, 1'b0);
    endtask

    // one accepted bit, then gap idle cycles; result due one cycle later
    task automatic send_bit(input logic b, input int gap, input string tag);
        in_valid = 1'b1; in_bit = b;
        hist[n] = b; n++;
        @(negedge clk);
        in_valid = 1'b0; in_bit = ~b;
        if (n >= N) begin
            chk({tag, " R4 pulse"}, match_valid, 1'b1);
            chk({tag, " R5 hit"}, match_hit, exp_hit());
        end else begin
            chk({tag, " R1 no pulse"}, match_valid, 1'b0);
            chk({tag, " R6 hit low"}, match_hit, 1'b0);
        end
        @(negedge clk);
        chk({tag, " R4 single"}, match_valid, 1'b0);
        chk({tag, " R6 hit low"}, match_hit, 1'b0);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk({tag, " R7 idle"}, match_valid, 1'b0);
        end
    endtask

    task automatic t_reset();
        do_reset(3'b101);
        repeat (5) begin
            @(negedge clk);
            chk("R1 idle", match_valid, 1'b0);
        end
    endtask

    task automatic t_example();
        logic [5:0] s = 6'b101011; // stream 1,1,0,1,0,1 (bit 0 first)
        logic got [4];
        int idx = 0;
        do_reset(3'b101);
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; in_bit = s[i]; hist[n] = s[i]; n++;
            @(negedge clk);
            in_valid = 1'b0;
            if (n >= N) begin got[idx] = match_hit; idx++; end
            @(negedge clk);
        end
        chk("R5 example w1", got[0], 1'b0);
        chk("R5 example w2", got[1], 1'b1);
        chk("R5 example w3", got[2], 1'b0);
        chk("R5 example w4", got[3], 1'b1);
    endtask

    task automatic t_overlap();
        logic [4:0] s = 5'b10101;
        do_reset(3'b101);
        for (int i = 0; i < 5; i++) send_bit(s[i], 0, "R8 overlap");
    endtask

    task automatic t_gaps();
        do_reset(3'b110);
        for (int i = 0; i < 12; i++) send_bit(1'(i % 3 != 0), i % 4 * 3, "R7 gaps");
    endtask

    task automatic t_pattern_change();
        do_reset(3'b011);
        for (int i = 0; i < 10; i++) begin
            pattern_in = 3'(i * 5 + 1);
            send_bit(1'(i % 2 == 0 || i % 3 == 0), 1, "R2 pattern frozen");
        end
    endtask

    task automatic t_back_to_back();
        do_reset(3'b111);
        send_bit(1'b1, 0, "R3 pre");
        send_bit(1'b1, 0, "R3 pre");
        in_valid = 1'b1; in_bit = 1'b1; hist[n] = 1'b1; n++;
        @(negedge clk);
        chk("R3 accepted pulse", match_valid, 1'b1);
        chk("R3 accepted hit", match_hit, 1'b1);
        in_bit = 1'b0; // strobe held: must be ignored
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 ignored no pulse", match_valid, 1'b0);
        // if the 0 were consumed the next window would miss
        send_bit(1'b1, 0, "R3 after ignore");
        chk("R3 window intact", 1'b1, exp_hit());
    endtask

    task automatic t_mid_reset();
        do_reset(3'b010);
        for (int i = 0; i < 4; i++) send_bit(1'(i % 2), 0, "R9 pre");
        do_reset(3'b010);
        for (int i = 0; i < 5; i++) send_bit(1'(i % 2), 1, "R9 refill");
    endtask

    task automatic t_random();
        for (int p = 0; p < 8; p++) begin
            do_reset(3'(p));
            for (int i = 0; i < 60; i++)
                send_bit(1'($urandom % 2), int'($urandom % 3), "R5 random");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_overlap();
        t_gaps();
        t_pattern_change();
        t_back_to_back();
        t_mid_reset();
        t_random();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule